// File: doc/BRIEF.md
# Programmable Rate Divider and Oscillator Control

This block turns a 32.768 kHz reference into the time bases of a clock/calendar. It samples the reference level on the system clock and treats each rising edge as one count. A 15-stage binary counter runs on those counts. A 4-bit rate code picks one counter stage. That stage drives a square-wave output and a one-cycle strobe that sets a periodic flag. The most significant stage supplies a once-per-second tick to the timekeeping logic.

A 3-bit control field sets the operating state. Its two upper bits start the oscillator, stop it, or keep it running while the counter is held at zero. The lowest bit has no effect on the divider and only selects a register bank. An override puts the reference level itself onto the square-wave output and ignores the rate code. All outputs are registered, and reset is synchronous and active high.

Top module: `rate_divider`

## Requirements
- R1: `bank_sel` equals `div_ctl[0]` one clock after it is applied (0 = bank 0, 1 = bank 1). Changing `div_ctl[0]` has no effect on the divider's pulses or square wave.
- R2: When `div_ctl[2:1]` = 2'b01 and `rate_sel` is not 0, `per_set` pulses high for exactly one clock per period of the selected stage, at that stage's rising edge. Stage k has a period of 2^(k+1) reference rising edges.
- R3: The rate code maps to stages as follows. Codes 1 and 2 select stages 6 and 7 (256 Hz and 128 Hz). Code c in the range 3..15 selects stage c-2, which runs from 8192 Hz at code 3 down to 2 Hz at code 15.
- R4: While `sqw_en` is 0, `sqw_out` is low, even when `sqw_fast` is 1.
- R5: When `sqw_en` is 1, `sqw_fast` is 0 and the counter is running, `sqw_out` is a square wave with 50 % duty cycle at the frequency of the selected stage.
- R6: When `sqw_en` and `sqw_fast` are both 1 and the oscillator is on, `sqw_out` follows the reference level, whatever the rate code (code 0 included).
- R7: Rate code 0 selects no stage. `per_set` then never pulses, and `sqw_out` stays low unless the override is active.
- R8: When `div_ctl[2:1]` = 2'b11, the counter is held at zero and no `per_set` or `sec_tick` pulse occurs. The oscillator stays on, so the override still passes the reference through.
- R9: When `div_ctl[2:1]` is 2'b00 or 2'b10, the oscillator is stopped. The counter keeps its value, no pulses occur, the square wave does not change, and the override output is low.
- R10: After a change from the held state to `div_ctl[2:1]` = 2'b01, the first `sec_tick` comes after 16384 reference rising edges (half a second). Each later tick comes 32768 rising edges after the one before.
- R11: During reset, `sqw_out`, `per_set`, `sec_tick` and `bank_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run faster than twice the reference |
| rst | input | 1 | Synchronous reset, active high |
| xtal_in | input | 1 | 32.768 kHz reference level, already synchronous to `clk` |
| div_ctl | input | 3 | [2:1] oscillator/counter mode, [0] bank select |
| rate_sel | input | 4 | Rate code that picks the stage |
| sqw_en | input | 1 | Square-wave output enable |
| sqw_fast | input | 1 | Override that passes the reference to `sqw_out` |
| sqw_out | output | 1 | Square-wave level |
| per_set | output | 1 | One-cycle periodic-flag set strobe |
| sec_tick | output | 1 | One-cycle 1 Hz update tick |
| bank_sel | output | 1 | Selected register bank |

## Verification
`bank_sel` changes one clock after `div_ctl` is applied. A counted reference edge updates the counter at the next clock edge. `sec_tick` is high in the cycle after that, and `per_set` and `sqw_out` one cycle later again. Because the added latency is the same for every pulse, the bench measures the spacing between successive pulses, which stays exact whatever the phase, rather than the absolute arrival times. The bench samples on the falling clock edge, settles for a few cycles after each change of configuration, and measures the square wave over windows that are whole multiples of its period. The first tick after release from hold is checked within a window of a few cycles, because the reference phase at release is not fixed. The interval between the first and second ticks is checked exactly.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;

  typedef enum logic [1:0] {
    OSC_STOP_A = 2'b00,
    OSC_RUN    = 2'b01,
    OSC_STOP_B = 2'b10,
    OSC_HOLD   = 2'b11
  } osc_mode_e;

  localparam int unsigned TAP_IDX_W = 5;

  // Stage picked by a nonzero rate code: the two slowest low codes wrap to
  // stages 6/7, the rest walk down from stage 1.
  function automatic logic [TAP_IDX_W-1:0] tap_of(input logic [3:0] code);
    logic [TAP_IDX_W-1:0] c;
    c = {1'b0, code};
    if (code < 4'd3) return c + 5'd5;
    return c - 5'd2;
  endfunction

endpackage

// File: rtl/rdiv_osc_ctl.sv
module rdiv_osc_ctl
  import rate_div_pkg::*;
#(
  parameter int unsigned CTL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xtal_in,
  input  logic [CTL_W-1:0] ctl,
  output logic             step,
  output logic             run,
  output logic             hold,
  output logic             ref_lvl,
  output logic             bank_sel
);

  osc_mode_e mode;
  logic      osc_on;
  logic      xtal_q;

  assign mode   = osc_mode_e'(ctl[2:1]);
  assign osc_on = ctl[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      xtal_q   <= 1'b0;
      bank_sel <= 1'b0;
    end else begin
      xtal_q   <= xtal_in & osc_on;
      bank_sel <= ctl[0];
    end
  end

  assign step    = osc_on & xtal_in & ~xtal_q;
  assign run     = (mode == OSC_RUN);
  assign hold    = (mode == OSC_HOLD);
  assign ref_lvl = xtal_q;

  // R9
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_on |=> !ref_lvl);

endmodule

// File: rtl/rdiv_chain.sv
module rdiv_chain #(
  parameter int unsigned STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              run,
  input  logic              hold,
  output logic [STAGES-1:0] cnt,
  output logic [STAGES-1:0] edge_q
);

  localparam int unsigned MSB = STAGES - 1;

  logic [STAGES-1:0] nxt;
  logic [STAGES-1:0] rise_c;
  logic              adv;

  assign adv = step & run;
  assign nxt = cnt + 1'b1;

  for (genvar k = 0; k < STAGES; k++) begin : g_rise
    assign rise_c[k] = adv & nxt[k] & ~cnt[k];
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt    <= '0;
      edge_q <= '0;
    end else begin
      edge_q <= rise_c;
      if (adv) cnt <= nxt;
    end
  end

  // R8
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0 && edge_q == '0));

  // R9
  stop_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !hold) |=> $stable(cnt));

  // R10
  tick_msb_chk: assert property (@(posedge clk) disable iff (rst)
    edge_q[MSB] |-> cnt[MSB]);

endmodule

// File: rtl/rdiv_tap_sel.sv
module rdiv_tap_sel
  import rate_div_pkg::*;
#(
  parameter int unsigned STAGES = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  input  logic              sqw_en,
  input  logic              fast_en,
  input  logic              ref_lvl,
  input  logic [STAGES-1:0] cnt,
  input  logic [STAGES-1:0] edge_q,
  output logic              sqw_out,
  output logic              per_set
);

  logic [TAP_IDX_W-1:0] tap_idx;
  logic                 tap_valid;
  logic [STAGES-1:0]    sel;
  logic                 tap_lvl;
  logic                 tap_edge;

  assign tap_valid = (rate != '0);
  assign tap_idx   = tap_of(rate[3:0]);

  for (genvar k = 0; k < STAGES; k++) begin : g_sel
    assign sel[k] = tap_valid && (tap_idx == TAP_IDX_W'(k));
  end

  assign tap_lvl  = |(cnt & sel);
  assign tap_edge = |(edge_q & sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      sqw_out <= 1'b0;
      per_set <= 1'b0;
    end else begin
      sqw_out <= sqw_en & (fast_en ? ref_lvl : tap_lvl);
      per_set <= tap_edge;
    end
  end

  // R4
  sqw_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sqw_en |=> !sqw_out);

  // R2
  per_single_chk: assert property (@(posedge clk) disable iff (rst)
    per_set |=> !per_set);

  // R7
  zero_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == '0) |=> !per_set);

endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int unsigned STAGES = 15,
  parameter int unsigned RATE_W = 4,
  parameter int unsigned CTL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xtal_in,
  input  logic [CTL_W-1:0]  div_ctl,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqw_en,
  input  logic              sqw_fast,
  output logic              sqw_out,
  output logic              per_set,
  output logic              sec_tick,
  output logic              bank_sel
);

  logic              step;
  logic              run;
  logic              hold;
  logic              ref_lvl;
  logic [STAGES-1:0] cnt;
  logic [STAGES-1:0] edge_q;

  rdiv_osc_ctl #(.CTL_W(CTL_W)) u_osc (
    .clk      (clk),
    .rst      (rst),
    .xtal_in  (xtal_in),
    .ctl      (div_ctl),
    .step     (step),
    .run      (run),
    .hold     (hold),
    .ref_lvl  (ref_lvl),
    .bank_sel (bank_sel)
  );

  rdiv_chain #(.STAGES(STAGES)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .run    (run),
    .hold   (hold),
    .cnt    (cnt),
    .edge_q (edge_q)
  );

  rdiv_tap_sel #(.STAGES(STAGES), .RATE_W(RATE_W)) u_tap (
    .clk     (clk),
    .rst     (rst),
    .rate    (rate_sel),
    .sqw_en  (sqw_en),
    .fast_en (sqw_fast),
    .ref_lvl (ref_lvl),
    .cnt     (cnt),
    .edge_q  (edge_q),
    .sqw_out (sqw_out),
    .per_set (per_set)
  );

  assign sec_tick = edge_q[STAGES-1];

  // R10
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);

  // R8
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (div_ctl[2:1] == 2'b11) |=> (!sec_tick && !per_set));

endmodule

// File: tb/rate_divider_bench.sv
module rate_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xtal_in = 1'b0;
  logic [2:0] div_ctl = 3'b110;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b0;
  logic       sqw_fast = 1'b0;
  logic       sqw_out, per_set, sec_tick, bank_sel;

  int n_checks = 0;
  int n_fail   = 0;

  rate_divider u_rate_divider (
    .clk(clk), .rst(rst), .xtal_in(xtal_in), .div_ctl(div_ctl),
    .rate_sel(rate_sel), .sqw_en(sqw_en), .sqw_fast(sqw_fast),
    .sqw_out(sqw_out), .per_set(per_set), .sec_tick(sec_tick),
    .bank_sel(bank_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference toggles every clock: one rising edge per two clocks.
  initial begin
    forever begin
      @(negedge clk);
      xtal_in = ~xtal_in;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] c, input logic [3:0] r, input logic en, input logic f);
    @(negedge clk);
    div_ctl = c; rate_sel = r; sqw_en = en; sqw_fast = f;
    repeat (6) @(negedge clk);
  endtask

  task automatic observe(input int n, output int tog, output int highs,
                         output int pulses, output int ticks);
    logic prev;
    tog = 0; highs = 0; pulses = 0; ticks = 0;
    @(negedge clk);
    prev = sqw_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sqw_out != prev) tog++;
      prev = sqw_out;
      if (sqw_out) highs++;
      if (per_set) pulses++;
      if (sec_tick) ticks++;
    end
  endtask

  task automatic interval(output int n);
    int g;
    g = 0;
    while (!per_set && g < 5000) begin @(negedge clk); g++; end
    @(negedge clk);
    while (!per_set && g < 5000) begin @(negedge clk); g++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!per_set && n < 5000);
  endtask

  task automatic t_reset;
    chk(sqw_out == 0 && per_set == 0 && sec_tick == 0 && bank_sel == 0, "R11",
        {sqw_out, per_set, sec_tick, bank_sel}, 0);
  endtask

  task automatic t_bank;
    @(negedge clk); div_ctl = 3'b111;
    @(negedge clk);
    chk(bank_sel == 1, "R1 bank1", bank_sel, 1);
    div_ctl = 3'b110;
    @(negedge clk);
    chk(bank_sel == 0, "R1 bank0", bank_sel, 0);
  endtask

  task automatic t_hold;
    int tg, hi, p, t;
    cfg(3'b110, 4'd3, 1'b1, 1'b0);
    observe(200, tg, hi, p, t);
    chk(p == 0 && t == 0, "R8 no pulses in hold", p + t, 0);
    chk(hi == 0, "R8 sqw low in hold", hi, 0);
    cfg(3'b110, 4'd3, 1'b1, 1'b1);
    observe(64, tg, hi, p, t);
    chk(tg == 64, "R8 override live in hold", tg, 64);
  endtask

  task automatic t_rates;
    int n, tg, hi, p, t;
    cfg(3'b010, 4'd3, 1'b1, 1'b0);
    interval(n); chk(n == 8, "R2 R3 code3 stage1", n, 8);
    observe(64, tg, hi, p, t);
    chk(tg == 16, "R5 code3 toggles", tg, 16);
    chk(hi == 32, "R5 code3 duty", hi, 32);
    chk(p == 8, "R2 code3 pulse count", p, 8);
    cfg(3'b010, 4'd4, 1'b1, 1'b0);
    interval(n); chk(n == 16, "R3 code4 stage2", n, 16);
    cfg(3'b010, 4'd1, 1'b1, 1'b0);
    interval(n); chk(n == 256, "R3 code1 stage6", n, 256);
    cfg(3'b010, 4'd2, 1'b1, 1'b0);
    interval(n); chk(n == 512, "R3 code2 stage7", n, 512);
    cfg(3'b010, 4'd8, 1'b1, 1'b0);
    interval(n); chk(n == 256, "R3 code8 stage6", n, 256);
    cfg(3'b011, 4'd3, 1'b1, 1'b0);
    interval(n); chk(n == 8, "R1 bank bit no effect", n, 8);
    chk(bank_sel == 1, "R1 bank1 while running", bank_sel, 1);
  endtask

  task automatic t_override;
    int tg, hi, p, t;
    cfg(3'b010, 4'd0, 1'b1, 1'b1);
    observe(64, tg, hi, p, t);
    chk(tg == 64, "R6 override with code0", tg, 64);
    cfg(3'b010, 4'd5, 1'b1, 1'b1);
    observe(64, tg, hi, p, t);
    chk(tg == 64, "R6 override ignores code5", tg, 64);
    cfg(3'b010, 4'd3, 1'b0, 1'b1);
    observe(64, tg, hi, p, t);
    chk(hi == 0 && tg == 0, "R4 disabled with override", hi + tg, 0);
    cfg(3'b010, 4'd3, 1'b0, 1'b0);
    observe(64, tg, hi, p, t);
    chk(hi == 0, "R4 disabled plain", hi, 0);
  endtask

  task automatic t_zero_rate;
    int tg, hi, p, t;
    cfg(3'b010, 4'd0, 1'b1, 1'b0);
    observe(300, tg, hi, p, t);
    chk(p == 0, "R7 no pulses code0", p, 0);
    chk(hi == 0, "R7 sqw low code0", hi, 0);
  endtask

  task automatic t_stopped;
    int tg, hi, p, t;
    cfg(3'b000, 4'd3, 1'b1, 1'b0);
    observe(200, tg, hi, p, t);
    chk(p == 0 && t == 0, "R9 no pulses stopped", p + t, 0);
    chk(tg == 0, "R9 sqw frozen stopped", tg, 0);
    cfg(3'b100, 4'd3, 1'b1, 1'b1);
    observe(64, tg, hi, p, t);
    chk(hi == 0 && tg == 0, "R9 override low stopped", hi + tg, 0);
  endtask

  task automatic t_tick;
    int n, g;
    cfg(3'b110, 4'd0, 1'b0, 1'b0);
    @(negedge clk); div_ctl = 3'b010;
    n = 0;
    do begin @(negedge clk); n++; end while (!sec_tick && n < 40000);
    chk(n >= 32764 && n <= 32772, "R10 first tick", n, 32768);
    g = 0;
    do begin @(negedge clk); g++; end while (!sec_tick && g < 70000);
    chk(g == 65536, "R10 tick period", g, 65536);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_bank();
    t_hold();
    t_rates();
    t_override();
    t_zero_rate();
    t_stopped();
    t_tick();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule